// File: doc/BRIEF.md
# SONET/SDH Serial Frame Aligner and Byte Deserializer

This block sits right behind the line receiver. It takes the recovered line data one bit per high-speed bit clock and hands it on as bytes, together with a byte clock that runs at one eighth of the bit rate. It also searches the bit stream for the section framing word, which is three A1 bytes (0xF6) followed at once by three A2 bytes (0x28). That word can sit at any of the eight bit offsets. When the search is allowed and the word is found, the byte boundary is moved so that the bit closing the third A2 also closes a byte. That A2 byte then leaves on the parallel output with a frame mark that lasts one byte period.

The search is allowed by a level input, `hunt_en`, which downstream logic raises while it is out of frame. While `hunt_en` is high, every new occurrence of the word re-aligns the boundary. After `hunt_en` drops, the block still accepts a word that completes before the current byte period ends. From then on the alignment is frozen and no mark is given. A loss-of-signal pin, with selectable polarity, forces the line data to zero ahead of both the search and the deserializer.

The search is a three-state machine:
- HOLD: the alignment is frozen.
- HUNT: `hunt_en` was high on the last bit.
- GRACE: released, waiting for the end of the current byte period.

Its transitions:
- HOLD to HUNT when `hunt_en` is sampled high.
- HUNT or GRACE back to HUNT while `hunt_en` is high.
- HUNT or GRACE to HOLD when `hunt_en` is low and either the byte boundary or an accepted word arrives.
- HUNT to GRACE when `hunt_en` is low and neither of those happens.

Top module: `sonet_rx_framer`

## Requirements
- R1: The byte clock `byte_clk` is low for four bit clocks after each byte boundary and high for the next four. `rx_byte` and `frame_mark` change only on a bit-clock edge after which `byte_clk` is low. Without re-alignment, consecutive rising edges of `byte_clk` are 8 bit clocks apart.
- R2: Each group of 8 line bits becomes one byte on `rx_byte`. The first bit received of the group lands in bit 7 and the last in bit 0. After reset, the first byte is formed from the first 8 bits sampled.
- R3: The framing word is recognised only as the exact 48-bit sequence F6 F6 F6 28 28 28 (MSB of each byte first), at any bit offset. Two A1 bytes followed by three A2 bytes, or three A1 bytes followed by only two A2 bytes, give no mark.
- R4: When the word is accepted, the byte holding its last 8 bits (0x28) is loaded at once. Every following byte is aligned to that boundary.
- R5: `frame_mark` rises together with the loaded 0x28 byte. It stays high for exactly 8 bit clocks, which is one byte period.
- R6: While `hunt_en` is high, the search keeps running after a word has been found. A later word at a different bit offset re-aligns the boundary again and gives a new mark.
- R7: When `hunt_en` is low and the block is in HOLD, a complete framing word causes no mark, and the existing byte boundary is kept.
- R8: If `hunt_en` falls, a word that completes on or before the bit closing the byte period in which it fell is still accepted. A word completing in a later byte period is ignored.
- R9: The line is in loss when `sig_lost` differs from `lost_active_low`. So with `lost_active_low`=0 the pin is active-high, and with 1 it is active-low. During loss every line bit is taken as 0, so a byte received entirely in loss reads 0x00 and no framing word is found.
- R10: A synchronous active-high `rst` clears `rx_byte` to 0x00 and `frame_mark` and `byte_clk` to 0. It restarts the bit count and returns the search to HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | High-speed bit clock; line data sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial line data |
| hunt_en | input | 1 | Out-of-frame level; high allows frame search and re-alignment |
| sig_lost | input | 1 | Loss-of-signal pin |
| lost_active_low | input | 1 | 0: `sig_lost` active-high; 1: active-low |
| byte_clk | output | 1 | Byte clock, bit clock divided by 8 |
| rx_byte | output | 8 | Received byte, stable across each rising edge of `byte_clk` |
| frame_mark | output | 1 | One-byte-period mark on the aligned third A2 byte |

## Verification
The bench drives the stream with the framing word at several bit offsets, so that a boundary left unmoved after a find is caught. It also sends truncated words with one A1 or one A2 missing; these are what show that matching takes all 48 bits and not a shorter prefix. A full word is placed with `hunt_en` low, and others with `hunt_en` falling either inside or just before the byte period in which the word completes; together these fix the exact length of the release window. Bytes of 0xFF and a framing word are sent under loss with both pin polarities, to show that the forcing happens upstream of both the search and the deserializer.

// File: rtl/sonet_rx_pkg.sv
package sonet_rx_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_GRACE = 2'd2
    } hunt_state_t;

endpackage

// File: rtl/rx_pattern_shifter.sv
module rx_pattern_shifter #(
    parameter int          BYTE_W  = 8,
    parameter int          REPEAT  = 3,
    parameter logic [7:0]  A1_CODE = 8'hF6,
    parameter logic [7:0]  A2_CODE = 8'h28,
    localparam int         PAT_W   = 2 * REPEAT * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             loss,
    output logic [PAT_W-1:0] window,
    output logic             match
);

    logic             line_bit;
    logic [PAT_W-2:0] hist_q;
    logic [PAT_W-1:0] pattern;

    // Line bit is forced low under loss before anything else sees it
    assign line_bit = loss ? 1'b0 : bit_in;
    assign window   = {hist_q, line_bit};

    // First-sent byte of the word occupies the most significant slice
    for (genvar g = 0; g < 2 * REPEAT; g++) begin : g_pat
        if (g < REPEAT) begin : g_a1
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A1_CODE[BYTE_W-1:0];
        end else begin : g_a2
            assign pattern[PAT_W-1-g*BYTE_W -: BYTE_W] = A2_CODE[BYTE_W-1:0];
        end
    end

    assign match = (window == pattern);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= window[PAT_W-2:0];
        end
    end

endmodule

// File: rtl/rx_byte_timer.sv
module rx_byte_timer #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic realign,
    output logic boundary,
    output logic byte_clk
);

    localparam int              CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(BYTE_W / 2);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign boundary = (cnt_q == LAST);

    always_comb begin
        if (realign || boundary) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            byte_clk <= 1'b0;
        end else begin
            cnt_q    <= cnt_nxt;
            byte_clk <= (cnt_nxt >= HALF);
        end
    end

endmodule

// File: rtl/rx_hunt_fsm.sv
module rx_hunt_fsm
    import sonet_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hunt_en,
    input  logic boundary,
    input  logic match,
    output logic take_frame
);

    hunt_state_t state_q;
    hunt_state_t state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (hunt_en) state_nxt = ST_HUNT;
            end
            ST_HUNT, ST_GRACE: begin
                if (hunt_en)                      state_nxt = ST_HUNT;
                else if (boundary || take_frame)  state_nxt = ST_HOLD;
                else                              state_nxt = ST_GRACE;
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        take_frame = 1'b0;
        unique case (state_q)
            ST_HOLD:           take_frame = match && hunt_en;
            ST_HUNT, ST_GRACE: take_frame = match;
            default:           take_frame = 1'b0;
        endcase
    end

endmodule

// File: rtl/rx_byte_launch.sv
module rx_byte_launch #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              realign,
    input  logic              boundary,
    input  logic [BYTE_W-1:0] new_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              frame_mark
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte    <= '0;
            frame_mark <= 1'b0;
        end else if (realign) begin
            rx_byte    <= new_byte;
            frame_mark <= 1'b1;
        end else if (boundary) begin
            rx_byte    <= new_byte;
            frame_mark <= 1'b0;
        end
    end

endmodule

// File: rtl/sonet_rx_framer.sv
module sonet_rx_framer #(
    parameter int         BYTE_W  = 8,
    parameter int         REPEAT  = 3,
    parameter logic [7:0] A1_CODE = 8'hF6,
    parameter logic [7:0] A2_CODE = 8'h28
) (
    input  logic              bit_clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              hunt_en,
    input  logic              sig_lost,
    input  logic              lost_active_low,
    output logic              byte_clk,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              frame_mark
);

    localparam int PAT_W = 2 * REPEAT * BYTE_W;

    logic             loss;
    logic [PAT_W-1:0] window;
    logic             match;
    logic             boundary;
    logic             take_frame;

    assign loss = sig_lost ^ lost_active_low;

    rx_pattern_shifter #(
        .BYTE_W (BYTE_W),
        .REPEAT (REPEAT),
        .A1_CODE(A1_CODE),
        .A2_CODE(A2_CODE)
    ) u_shift (
        .clk   (bit_clk),
        .rst   (rst),
        .bit_in(ser_in),
        .loss  (loss),
        .window(window),
        .match (match)
    );

    rx_hunt_fsm u_fsm (
        .clk       (bit_clk),
        .rst       (rst),
        .hunt_en   (hunt_en),
        .boundary  (boundary),
        .match     (match),
        .take_frame(take_frame)
    );

    rx_byte_timer #(
        .BYTE_W(BYTE_W)
    ) u_timer (
        .clk     (bit_clk),
        .rst     (rst),
        .realign (take_frame),
        .boundary(boundary),
        .byte_clk(byte_clk)
    );

    rx_byte_launch #(
        .BYTE_W(BYTE_W)
    ) u_launch (
        .clk       (bit_clk),
        .rst       (rst),
        .realign   (take_frame),
        .boundary  (boundary),
        .new_byte  (window[BYTE_W-1:0]),
        .rx_byte   (rx_byte),
        .frame_mark(frame_mark)
    );

endmodule

// File: rtl/sonet_rx_framer_chk.sv
module sonet_rx_framer_chk #(
    parameter int         BYTE_W  = 8,
    parameter logic [7:0] A2_CODE = 8'h28
) (
    input logic              bit_clk,
    input logic              rst,
    input logic              hunt_en,
    input logic              sig_lost,
    input logic              lost_active_low,
    input logic              byte_clk,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              frame_mark
);

    localparam logic [7:0] SAT  = 8'hFF;
    localparam logic [7:0] BW8  = 8'(BYTE_W);
    localparam logic [7:0] HALF = 8'(BYTE_W / 2);

    logic [7:0] hi_run;
    logic [7:0] mark_run;
    logic [7:0] since_hunt;
    logic [7:0] los_run;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            hi_run     <= '0;
            mark_run   <= '0;
            since_hunt <= SAT;
            los_run    <= '0;
        end else begin
            hi_run     <= !byte_clk ? 8'd0 : (hi_run != SAT ? hi_run + 8'd1 : SAT);
            mark_run   <= !frame_mark ? 8'd0 : (mark_run != SAT ? mark_run + 8'd1 : SAT);
            since_hunt <= hunt_en ? 8'd0 : (since_hunt != SAT ? since_hunt + 8'd1 : SAT);
            los_run    <= !(sig_lost ^ lost_active_low) ? 8'd0
                          : (los_run != SAT ? los_run + 8'd1 : SAT);
        end
    end

    AST_STABLE_WHILE_HIGH: assert property (@(posedge bit_clk) disable iff (rst)
        byte_clk |-> ($stable(rx_byte) && $stable(frame_mark))); // R1

    AST_BCLK_HIGH_RUN: assert property (@(posedge bit_clk) disable iff (rst)
        hi_run <= HALF); // R1

    AST_MARK_ON_A2: assert property (@(posedge bit_clk) disable iff (rst)
        $rose(frame_mark) |-> (rx_byte == A2_CODE[BYTE_W-1:0])); // R5

    AST_MARK_ONE_BYTE: assert property (@(posedge bit_clk) disable iff (rst)
        $fell(frame_mark) |-> (mark_run == BW8)); // R5

    AST_NO_MARK_AFTER_GRACE: assert property (@(posedge bit_clk) disable iff (rst)
        $rose(frame_mark) |-> (since_hunt <= BW8)); // R8

    AST_LOSS_ZERO_BYTE: assert property (@(posedge bit_clk) disable iff (rst)
        ($fell(byte_clk) && (los_run >= BW8)) |-> (rx_byte == '0)); // R9

    AST_RESET_CLEARS: assert property (@(posedge bit_clk)
        rst |=> (rx_byte == '0 && !frame_mark && !byte_clk)); // R10

endmodule

bind sonet_rx_framer sonet_rx_framer_chk #(
    .BYTE_W (BYTE_W),
    .A2_CODE(A2_CODE)
) u_chk (
    .bit_clk        (bit_clk),
    .rst            (rst),
    .hunt_en        (hunt_en),
    .sig_lost       (sig_lost),
    .lost_active_low(lost_active_low),
    .byte_clk       (byte_clk),
    .rx_byte        (rx_byte),
    .frame_mark     (frame_mark)
);

// File: tb/test_sonet_rx_framer.sv
module test_sonet_rx_framer;

    localparam int          CLK_PERIOD = 10;
    localparam logic [47:0] WORD       = 48'hF6F6F6282828;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       hunt_en = 1'b0;
    logic       sig_lost = 1'b0;
    logic       lost_active_low = 1'b0;
    logic       byte_clk;
    logic [7:0] rx_byte;
    logic       frame_mark;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sonet_rx_framer i_sonet_rx_framer (
        .bit_clk        (clk),
        .rst            (rst),
        .ser_in         (ser_in),
        .hunt_en        (hunt_en),
        .sig_lost       (sig_lost),
        .lost_active_low(lost_active_low),
        .byte_clk       (byte_clk),
        .rx_byte        (rx_byte),
        .frame_mark     (frame_mark)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Behavioural reference: history of line bits, bit position in byte, release flag
    logic [63:0] m_hist;
    int          m_pos;
    bit          m_armed;
    logic [7:0]  m_byte;
    bit          m_mark;
    bit          m_bclk;

    always @(posedge clk) begin : ref_model
        logic        b;
        logic [47:0] win;
        bit          hit;
        bit          at_end;
        cyc++;
        if (rst) begin
            m_hist = '0; m_pos = 0; m_armed = 0; m_byte = '0; m_mark = 0; m_bclk = 0;
        end else begin
            b      = (sig_lost != lost_active_low) ? 1'b0 : ser_in;
            win    = {m_hist[46:0], b};
            m_hist = {m_hist[62:0], b};
            hit    = (hunt_en || m_armed) && (win == WORD);
            at_end = (m_pos == 7);
            if (hit) begin
                m_pos = 0; m_byte = win[7:0]; m_mark = 1;
            end else if (at_end) begin
                m_pos = 0; m_byte = win[7:0]; m_mark = 0;
            end else begin
                m_pos++;
            end
            if (hunt_en)            m_armed = 1;
            else if (hit || at_end) m_armed = 0;
            m_bclk = (m_pos >= 4);
        end
    end

    // Clock-by-clock comparison against the reference
    always @(negedge clk) begin
        if (!done) begin
            chk("R1 byte_clk", int'(byte_clk), int'(m_bclk));
            chk("R2 rx_byte", int'(rx_byte), int'(m_byte));
            chk("R5 frame_mark", int'(frame_mark), int'(m_mark));
        end
    end

    // Byte monitor: captures data at each rising edge of the byte clock
    int         mark_cnt = 0;
    int         zero_cnt = 0;
    logic [7:0] mark_byte = '0;
    logic [7:0] after_byte = '0;
    logic [7:0] last_byte = '0;
    bit         want_next = 0;
    bit         bclk_prev = 0;
    int         last_rise = 0;
    int         period = 0;

    always @(negedge clk) begin
        if (rst) begin
            bclk_prev = 0;
        end else begin
            if (!bclk_prev && byte_clk) begin
                period    = cyc - last_rise;
                last_rise = cyc;
                last_byte = rx_byte;
                if (rx_byte == 8'h00) zero_cnt++;
                if (frame_mark) begin
                    mark_cnt++;
                    mark_byte = rx_byte;
                    want_next = 1;
                end else if (want_next) begin
                    after_byte = rx_byte;
                    want_next  = 0;
                end
            end
            bclk_prev = byte_clk;
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000 && !done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected<=60000", cyc);
            finish_up();
        end
    end

    task automatic send_bit(input logic b);
        ser_in = b;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic send_word(input int drop_at);
        for (int i = 0; i < 48; i++) begin
            if (i == drop_at) hunt_en = 1'b0;
            send_bit(WORD[47-i]);
        end
    endtask

    initial begin
        int base;
        int zbase;
        repeat (3) @(negedge clk);
        chk("R10 reset rx_byte", int'(rx_byte), 0);
        chk("R10 reset frame_mark", int'(frame_mark), 0);
        chk("R10 reset byte_clk", int'(byte_clk), 0);
        rst = 1'b0;

        // First byte after reset, MSB first
        send_byte(8'hC3);
        send_byte(8'h00);
        #1 chk("R2 first byte", int'(last_byte), 8'hC3);

        // Word at a 5-bit offset with the search allowed
        hunt_en = 1'b1;
        base = mark_cnt;
        send_zeros(5);
        send_word(-1);
        send_byte(8'h11);
        send_byte(8'h22);
        #1;
        chk("R3 mark count", mark_cnt - base, 1);
        chk("R5 marked byte", int'(mark_byte), 8'h28);
        chk("R4 byte after mark", int'(after_byte), 8'h11);

        // Truncated words
        base = mark_cnt;
        send_byte(8'hF6); send_byte(8'hF6); send_byte(8'h28);
        send_byte(8'h28); send_byte(8'h28); send_byte(8'h00);
        send_byte(8'hF6); send_byte(8'hF6); send_byte(8'hF6);
        send_byte(8'h28); send_byte(8'h28); send_byte(8'h00);
        send_byte(8'h00);
        #1 chk("R3 truncated words", mark_cnt - base, 0);

        // Repeated search, two offsets
        base = mark_cnt;
        send_zeros(5);
        send_word(-1);
        send_byte(8'h33);
        send_zeros(2);
        send_word(-1);
        send_byte(8'h44);
        send_byte(8'h00);
        #1;
        chk("R6 mark count", mark_cnt - base, 2);
        chk("R6 byte after second mark", int'(after_byte), 8'h44);

        // Search off: word ignored, boundary kept
        hunt_en = 1'b0;
        base = mark_cnt;
        send_byte(8'h00);
        send_zeros(3);
        send_word(-1);
        send_byte(8'h55);
        send_zeros(5);
        send_byte(8'h00);
        #1;
        chk("R7 no mark in HOLD", mark_cnt - base, 0);
        chk("R7 old boundary byte", int'(last_byte), 8'hA0);
        chk("R1 byte_clk period", period, 8);

        // Release inside the byte period in which the word completes
        hunt_en = 1'b1;
        base = mark_cnt;
        send_byte(8'h00);
        send_zeros(3);
        send_word(46);
        send_byte(8'h66);
        send_byte(8'h00);
        #1;
        chk("R8 grace mark", mark_cnt - base, 1);
        chk("R8 grace byte after", int'(after_byte), 8'h66);

        // Release one byte period too early
        hunt_en = 1'b1;
        base = mark_cnt;
        send_byte(8'h00);
        send_zeros(3);
        send_word(40);
        send_byte(8'h77);
        send_zeros(5);
        send_byte(8'h00);
        #1 chk("R8 late word ignored", mark_cnt - base, 0);

        // Loss, active-high pin
        hunt_en = 1'b1;
        lost_active_low = 1'b0;
        base  = mark_cnt;
        send_byte(8'hFF); send_byte(8'hFF);
        zbase = zero_cnt;
        sig_lost = 1'b1;
        send_byte(8'hFF); send_byte(8'hFF);
        send_word(-1);
        send_byte(8'hFF);
        sig_lost = 1'b0;
        send_byte(8'hFF); send_byte(8'hFF);
        #1;
        chk("R9 no mark under loss", mark_cnt - base, 0);
        chk("R9 zero bytes under loss", int'((zero_cnt - zbase) >= 8), 1);
        chk("R9 data back after loss", int'(last_byte), 8'hFF);

        // Loss, active-low pin
        lost_active_low = 1'b1;
        sig_lost = 1'b1;
        send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF);
        #1 chk("R9 active-low pin high passes", int'(last_byte), 8'hFF);
        sig_lost = 1'b0;
        send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF);
        #1 chk("R9 active-low pin low forces", int'(last_byte), 8'h00);
        lost_active_low = 1'b0;

        // Reset in mid-stream
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R10 rx_byte after reset", int'(rx_byte), 0);
        chk("R10 frame_mark after reset", int'(frame_mark), 0);
        chk("R10 byte_clk after reset", int'(byte_clk), 0);
        rst = 1'b0;
        send_byte(8'hA5);
        send_byte(8'h00);
        #1 chk("R10 count restarts", int'(last_byte), 8'hA5);

        @(negedge clk);
        finish_up();
    end

endmodule